// File: doc/BRIEF.md
# Microcode RAM Byte Loader

This block lets a host with an 8-bit register port fill and inspect a 32-bit-wide sequencer instruction memory. The host picks a word location by writing the low and high bytes of a word pointer. It then pushes bytes one at a time into a single window register, least significant byte first. The first three bytes are held in a staging bank. The fourth byte completes the word. That write stores the whole word into the memory and moves the pointer to the next location.

Reading the window walks the memory the same way. Each read returns one byte lane of the word at the pointer and advances the lane, and the read of the top lane advances the pointer. A load-enable bit in the control register gates all window traffic. A self-clearing bit in the same register returns the pointer to location zero. A separate fetch port, used by the sequencer, reads whole words with one cycle of latency.

The register select encoding is 0 for control, 1 for pointer low byte, 2 for pointer high byte and 3 for the data window. The control register holds the load-enable flag in bit 0 and the pointer-clear strobe in bit 1.

Top module: `ucode_loader`

## Requirements
- R1: After reset the word pointer and byte lane are zero, loading is disabled, and reads of select 0, 1 and 2 return 0x00.
- R2: A write to select 1 sets pointer bits 7:0. A write to select 2 sets pointer bit 8 from data bit 0, and the other data bits are dropped. A read of select 2 returns the pointer's upper bits zero-extended, so it reads 0x01 after 0xFF is written.
- R3: A write to select 1, select 2 or select 0 returns the byte lane to 0, and bytes already staged in the partial word are abandoned.
- R4: With loading enabled, four window writes b0,b1,b2,b3 store the word {b3,b2,b1,b0} at the pointer on the fourth write. The first three writes store nothing.
- R5: The pointer increments by one on the fourth byte of a word and on no other byte, and it wraps from 511 to 0.
- R6: With loading enabled, a read of select 3 returns bits 8*lane+7:8*lane of the word at the pointer and advances the lane. The read of lane 3 also increments the pointer.
- R7: With loading disabled, window writes store nothing and move neither the pointer nor the lane. Window reads return 0x00 and move nothing.
- R8: Writing control bit 0 sets or clears load enable, and it reads back in bit 0. Writing 1 to control bit 1 zeroes the pointer. That bit always reads back as 0.
- R9: The fetch port returns the word at fetch_addr one clock edge later. When a commit hits the same location at that edge, the port returns the old word, and the new word appears on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select (0 control, 1 pointer low, 2 pointer high, 3 window) |
| reg_wr | input | 1 | Register write strobe, one access per cycle |
| reg_rd | input | 1 | Register read strobe; ignored when reg_wr is high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of the selected register |
| fetch_addr | input | ADDR_W | Sequencer fetch word address |
| fetch_data | output | 32 | Registered fetch word |

## Verification
The commit of a completed word and a sequencer fetch of that same location can land on the same clock edge. The bench sets up this overlap on purpose. It stages three bytes, then puts the fourth window write and a fetch of that address in the same cycle. It expects the previous contents on the first edge and the new word on the next edge. A second overlap is a pointer register write in the middle of a word, which has to abandon the staged bytes. The bench judges this through the word that a later complete write stores.

// File: rtl/ucl_pkg.sv
package ucl_pkg;

    localparam int REG_BYTE_W  = 8;
    localparam int CTRL_LOAD_B = 0;
    localparam int CTRL_CLR_B  = 1;
    localparam int PTR_LO_W    = 8;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PTR_LO = 2'd1,
        SEL_PTR_HI = 2'd2,
        SEL_WINDOW = 2'd3
    } ucl_sel_e;

    typedef struct packed {
        logic                  ctrl_wr;
        logic                  ptr_clr;
        logic                  lo_wr;
        logic                  hi_wr;
        logic                  win_wr;
        logic                  win_rd;
        logic [REG_BYTE_W-1:0] data;
    } ucl_cmd_t;

    function automatic logic lane_resets(ucl_cmd_t c);
        return c.ctrl_wr | c.lo_wr | c.hi_wr;
    endfunction

    function automatic logic win_access(ucl_cmd_t c);
        return c.win_wr | c.win_rd;
    endfunction

endpackage

// File: rtl/ucl_host_if.sv
module ucl_host_if
    import ucl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            reg_sel,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_BYTE_W-1:0] reg_wdata,
    output ucl_cmd_t              cmd,
    output logic                  load_en
);

    ucl_sel_e sel;
    logic     load_en_q;

    assign sel     = ucl_sel_e'(reg_sel);
    assign load_en = load_en_q;

    always_comb begin
        cmd      = '0;
        cmd.data = reg_wdata;
        if (reg_wr) begin
            unique case (sel)
                SEL_CTRL: begin
                    cmd.ctrl_wr = 1'b1;
                    cmd.ptr_clr = reg_wdata[CTRL_CLR_B];
                end
                SEL_PTR_LO: cmd.lo_wr  = 1'b1;
                SEL_PTR_HI: cmd.hi_wr  = 1'b1;
                SEL_WINDOW: cmd.win_wr = load_en_q;
                default: ;
            endcase
        end else if (reg_rd && sel == SEL_WINDOW) begin
            cmd.win_rd = load_en_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_en_q <= 1'b0;
        end else if (cmd.ctrl_wr) begin
            load_en_q <= reg_wdata[CTRL_LOAD_B];
        end
    end

endmodule

// File: rtl/ucl_lane_seq.sv
module ucl_lane_seq
    import ucl_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int LANES  = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  ucl_cmd_t                       cmd,
    output logic [ADDR_W-1:0]              ptr,
    output logic [$clog2(LANES)-1:0]       lane,
    output logic                           commit_we,
    output logic [LANES*REG_BYTE_W-1:0]    commit_word
);

    localparam int LANE_W = $clog2(LANES);
    localparam int LAST   = LANES - 1;
    localparam int HI_W   = ADDR_W - PTR_LO_W;

    logic [ADDR_W-1:0]                  ptr_q;
    logic [LANE_W-1:0]                  lane_q;
    logic [LANES-1:0][REG_BYTE_W-1:0]   stage_q;
    logic                               lane_last;

    assign ptr       = ptr_q;
    assign lane      = lane_q;
    assign lane_last = (lane_q == LANE_W'(LAST));
    assign commit_we = cmd.win_wr && lane_last;

    generate
        for (genvar i = 0; i < LAST; i++) begin : g_staged
            assign commit_word[i*REG_BYTE_W +: REG_BYTE_W] = stage_q[i];
        end
    endgenerate
    assign commit_word[LAST*REG_BYTE_W +: REG_BYTE_W] = cmd.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            lane_q  <= '0;
            stage_q <= '0;
        end else begin
            if (cmd.win_wr && !lane_last) begin
                stage_q[lane_q] <= cmd.data;
            end

            if (cmd.ptr_clr) begin
                ptr_q <= '0;
            end else if (cmd.lo_wr) begin
                ptr_q[PTR_LO_W-1:0] <= cmd.data;
            end else if (cmd.hi_wr) begin
                ptr_q[ADDR_W-1:PTR_LO_W] <= cmd.data[HI_W-1:0];
            end else if (win_access(cmd) && lane_last) begin
                ptr_q <= ptr_q + 1'b1;
            end

            if (lane_resets(cmd)) begin
                lane_q <= '0;
            end else if (win_access(cmd)) begin
                lane_q <= lane_last ? '0 : lane_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ucl_ram.sv
module ucl_ram #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] win_addr,
    output logic [WORD_W-1:0] win_word,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [WORD_W-1:0] fetch_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] fetch_q;

    assign win_word   = mem[win_addr];
    assign fetch_word = fetch_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_q <= '0;
        end else begin
            fetch_q <= mem[fetch_addr];
        end
    end

endmodule

// File: rtl/ucode_loader.sv
module ucode_loader
    import ucl_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int LANES  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [1:0]                  reg_sel,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [7:0]                  reg_wdata,
    output logic [7:0]                  reg_rdata,
    input  logic [ADDR_W-1:0]           fetch_addr,
    output logic [LANES*8-1:0]          fetch_data
);

    localparam int WORD_W = LANES * REG_BYTE_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int HI_W   = ADDR_W - PTR_LO_W;

    ucl_cmd_t            cmd;
    logic                load_en_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [LANE_W-1:0]   lane_q;
    logic                commit_we;
    logic [WORD_W-1:0]   commit_word;
    logic [WORD_W-1:0]   win_word;

    ucl_host_if u_host (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .cmd       (cmd),
        .load_en   (load_en_q)
    );

    ucl_lane_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .ptr         (addr_q),
        .lane        (lane_q),
        .commit_we   (commit_we),
        .commit_word (commit_word)
    );

    ucl_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
        .clk        (clk),
        .rst        (rst),
        .we         (commit_we),
        .waddr      (addr_q),
        .wdata      (commit_word),
        .win_addr   (addr_q),
        .win_word   (win_word),
        .fetch_addr (fetch_addr),
        .fetch_word (fetch_data)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (ucl_sel_e'(reg_sel))
            SEL_CTRL:   reg_rdata[CTRL_LOAD_B] = load_en_q;
            SEL_PTR_LO: reg_rdata = addr_q[PTR_LO_W-1:0];
            SEL_PTR_HI: reg_rdata[HI_W-1:0] = addr_q[ADDR_W-1:PTR_LO_W];
            SEL_WINDOW: reg_rdata = load_en_q ? win_word[lane_q*REG_BYTE_W +: REG_BYTE_W] : '0;
            default: ;
        endcase
    end

endmodule

// File: rtl/ucode_loader_chk.sv
module ucode_loader_chk #(
    parameter int ADDR_W = 9,
    parameter int LANES  = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic [1:0]               reg_sel,
    input logic                     reg_wr,
    input logic [7:0]               reg_rdata,
    input logic [ADDR_W-1:0]        cur_addr,
    input logic [$clog2(LANES)-1:0] cur_lane,
    input logic                     load_en
);

    localparam int LANE_W = $clog2(LANES);
    localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);

    p_reset_state_r1: assert property (@(posedge clk)
        $fell(rst) |-> (cur_addr == '0 && cur_lane == '0 && !load_en));

    p_ptr_wr_clears_lane_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_sel == 2'd1 || reg_sel == 2'd2)) |=> (cur_lane == '0));

    p_midword_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd3 && load_en && cur_lane != LAST) |=> $stable(cur_addr));

    p_top_lane_step_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd3 && load_en && cur_lane == LAST)
        |=> (cur_addr == $past(cur_addr) + 1'b1 && cur_lane == '0));

    p_disabled_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd3 && !load_en) |=> ($stable(cur_addr) && $stable(cur_lane)));

    p_disabled_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd3 && !load_en) |-> (reg_rdata == 8'h00));

    p_clr_bit_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd0) |-> (reg_rdata[1] == 1'b0));

endmodule

bind ucode_loader ucode_loader_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .cur_addr  (addr_q),
    .cur_lane  (lane_q),
    .load_en   (load_en_q)
);

// File: tb/ucode_loader_bench.sv
`timescale 1ns/1ps
module ucode_loader_bench;

    localparam int AW    = 9;
    localparam int DEPTH = 1 << AW;
    localparam logic [1:0] S_CTRL = 2'd0, S_LO = 2'd1, S_HI = 2'd2, S_WIN = 2'd3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    reg_sel = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [AW-1:0] fetch_addr = '0;
    logic [31:0]   fetch_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [31:0] mdl [DEPTH];

    always #4 clk = ~clk;

    ucode_loader u_ucode_loader (
        .clk        (clk),
        .rst        (rst),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .fetch_addr (fetch_addr),
        .fetch_data (fetch_data)
    );

    function automatic logic [31:0] pat(int a, int salt);
        return (32'(a) * 32'h0100_0193) ^ 32'hC3A5_0F1E ^ 32'(salt);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] s, logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic set_ptr(int a);
        wr(S_LO, 8'(a));
        wr(S_HI, 8'(a >> 8));
    endtask

    task automatic put_word(logic [31:0] w);
        for (int b = 0; b < 4; b++) wr(S_WIN, w[b*8 +: 8]);
    endtask

    task automatic fetch(int a, output logic [31:0] w);
        @(negedge clk);
        fetch_addr = AW'(a);
        @(posedge clk); #1;
        w = fetch_data;
    endtask

    task automatic read_ptr(output int a);
        logic [7:0] lo, hi;
        rd(S_LO, lo);
        rd(S_HI, hi);
        a = {hi, lo};
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] w;
        int          a;
        int          nbad;

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        rd(S_CTRL, b); chk("R1 ctrl", b, 8'h00);
        rd(S_LO, b);   chk("R1 ptr lo", b, 8'h00);
        rd(S_HI, b);   chk("R1 ptr hi", b, 8'h00);
        // R7: disabled window read
        rd(S_WIN, b);  chk("R7 read while disabled", b, 8'h00);

        // R8: enable load
        wr(S_CTRL, 8'h01);
        rd(S_CTRL, b); chk("R8 load enable readback", b, 8'h01);

        // R2: pointer registers, upper bits of hi dropped
        wr(S_HI, 8'hFF);
        rd(S_HI, b);   chk("R2 hi keeps bit0 only", b, 8'h01);
        wr(S_LO, 8'h3C);
        read_ptr(a);   chk("R2 full pointer", 32'(a), 32'h13C);

        // R4/R5: fill the whole array from 0, pointer wraps back to 0
        set_ptr(0);
        for (int i = 0; i < DEPTH; i++) begin
            mdl[i] = pat(i, 0);
            put_word(mdl[i]);
        end
        read_ptr(a);   chk("R5 wrap after full fill", 32'(a), 0);

        // R4/R9: fetch sweep over every word
        nbad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            fetch(i, w);
            if (w !== mdl[i]) nbad++;
        end
        chk("R4 fetch sweep mismatches", 32'(nbad), 0);

        // R8: pointer clear strobe, self-clearing bit
        set_ptr(9'h0F0);
        wr(S_CTRL, 8'h03);
        rd(S_CTRL, b); chk("R8 clear bit reads zero", b, 8'h01);
        read_ptr(a);   chk("R8 pointer cleared", 32'(a), 0);

        // R6: window read sweep of every byte
        nbad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            for (int l = 0; l < 4; l++) begin
                rd(S_WIN, b);
                if (b !== mdl[i][l*8 +: 8]) nbad++;
            end
        end
        chk("R6 window read sweep mismatches", 32'(nbad), 0);
        read_ptr(a);   chk("R6 pointer wrapped after reads", 32'(a), 0);

        // R5: pointer held mid-word, steps on the fourth byte
        set_ptr(9'h1A5);
        w = 32'hDEAD_BEEF;
        for (int l = 0; l < 3; l++) wr(S_WIN, w[l*8 +: 8]);
        rd(S_LO, b);   chk("R5 pointer held mid-word", b, 8'hA5);
        fetch(9'h1A5, w); chk("R4 no commit before fourth byte", w, mdl[9'h1A5]);
        wr(S_WIN, 8'hDE);
        rd(S_LO, b);   chk("R5 pointer stepped", b, 8'hA6);
        mdl[9'h1A5] = 32'hDEAD_BEEF;
        fetch(9'h1A5, w); chk("R4 word committed LSB first", w, 32'hDEAD_BEEF);

        // R5: wrap from 511
        set_ptr(511);
        mdl[511] = 32'h0BAD_F00D;
        put_word(mdl[511]);
        read_ptr(a);   chk("R5 wrap 511 to 0", 32'(a), 0);

        // R3: pointer write mid-word abandons staged bytes
        set_ptr(5);
        wr(S_WIN, 8'h11); wr(S_WIN, 8'h22);
        wr(S_LO, 8'h05);
        put_word(32'h4433_2211 ^ 32'h8080_8080);
        mdl[5] = 32'h4433_2211 ^ 32'h8080_8080;
        fetch(5, w);   chk("R3 lane restarted by pointer write", w, mdl[5]);
        read_ptr(a);   chk("R3 pointer after restart", 32'(a), 6);

        // R3: control write mid-read restarts lane
        set_ptr(6);
        rd(S_WIN, b); rd(S_WIN, b);
        wr(S_CTRL, 8'h01);
        rd(S_WIN, b);  chk("R3 lane reset by control write", b, mdl[6][7:0]);

        // R7: disabled writes store nothing and move nothing
        set_ptr(7);
        wr(S_CTRL, 8'h00);
        put_word(32'h1234_5678);
        read_ptr(a);   chk("R7 pointer unchanged", 32'(a), 7);
        fetch(7, w);   chk("R7 no commit while disabled", w, mdl[7]);
        wr(S_CTRL, 8'h01);
        rd(S_WIN, b);  chk("R7 lane unchanged (lane0 read)", b, mdl[7][7:0]);

        // R9: commit and fetch of the same word on one edge
        set_ptr(9);
        wr(S_WIN, 8'hA1); wr(S_WIN, 8'hB2); wr(S_WIN, 8'hC3);
        @(negedge clk);
        fetch_addr = 9; reg_sel = S_WIN; reg_wdata = 8'hD4; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        chk("R9 same-edge fetch sees old word", fetch_data, mdl[9]);
        @(posedge clk); #1;
        chk("R9 next edge sees new word", fetch_data, 32'hD4C3_B2A1);

        finish_run();
    end

endmodule